// File: doc/BRIEF.md
# Power Mode and Clock Source Controller

This block chooses which oscillator feeds the CPU and peripheral clock trees and decides whether each tree is gated. A register write loads an idle-enable bit and a 2-bit source-select field. A one-cycle sleep strobe takes the block out of run. It goes to idle if idle-enable is set at that moment and to full sleep otherwise. A one-cycle wake strobe brings it back to run.

A change of source only takes hold when the requested oscillator reports ready. Until then the block stays on the present source and raises a pending flag. The outputs are a source mux control, two clock enables and a 3-bit mode code.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the block is in primary run: mode_code=2, src_mux=2'b10, cpu_clk_en=1, per_clk_en=1, switch_pending=0, and idle-enable is cleared.
- R2: The mode_code is 0 in sleep. In run and idle it is {idle,src}: PRI_RUN=2, SEC_RUN=1, RC_RUN=3, PRI_IDLE=6, SEC_IDLE=5, RC_IDLE=7. In run both enables are 1. In idle cpu_clk_en=0 and per_clk_en=1. In sleep both enables are 0.
- R3: The source encoding is 2'b10 primary, 2'b01 secondary and 2'b11 internal. A select value of 2'b00 means primary, so src_mux reads 2'b10 for it.
- R4: A sleep_cmd in run enters idle if the stored idle-enable is 1 and sleep if it is 0. The new mode is visible after the clock edge that samples the strobe.
- R5: The idle-enable value used is the stored value, taken before any write in the same cycle. Writes made after entry do not change the mode.
- R6: A write whose target source is ready changes src_mux at the edge that takes the write, and switch_pending stays 0.
- R7: If the target source is not ready, src_mux keeps the old source and switch_pending=1. After the target's ready input rises, the switch happens on the next edge and pending clears.
- R8: A wake_cmd in idle or sleep returns the block to run on the current source. A wake_cmd in run is ignored. A sleep_cmd in idle or sleep is ignored.
- R9: Source writes and switches still work in idle and in sleep. In sleep src_mux reads 2'b00 (no source).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idle_en | input | 1 | Idle-enable value to write |
| wr_src_sel | input | 2 | Source-select value to write |
| sleep_cmd | input | 1 | One-cycle sleep strobe |
| wake_cmd | input | 1 | One-cycle wake strobe |
| pri_rdy | input | 1 | Primary oscillator running |
| sec_rdy | input | 1 | Secondary oscillator running |
| rc_rdy | input | 1 | Internal oscillator running |
| src_mux | output | 2 | Active source code, 00 in sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_code | output | 3 | Current mode code |
| switch_pending | output | 1 | Requested source not yet active |

## Verification
The bench sweeps every idle-enable and select pair through the cycle run, sleep command, wake. A design that mapped idle and sleep the wrong way round, or mishandled select 00, would show a wrong mode code or source at once. A sleep strobe is given in the same cycle as a write that flips idle-enable. A design that used the incoming value would end up in idle when it should be in sleep. Every ordered pair of distinct sources is also tried with the target held not ready. A design that switched early would change src_mux or drop pending before ready rises, and one that never retried would stay stuck on the old source.

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_idle_en,
  input  logic [1:0] wr_src_sel,
  input  logic       sleep_cmd,
  input  logic       wake_cmd,
  input  logic       pri_rdy,
  input  logic       sec_rdy,
  input  logic       rc_rdy,
  output logic [1:0] src_mux,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic [2:0] mode_code,
  output logic       switch_pending
);
  localparam logic [1:0] SRC_PRI = 2'b10;
  localparam logic [1:0] SRC_SEC = 2'b01;
  localparam logic [1:0] SRC_RC  = 2'b11;

  typedef enum logic [1:0] {M_RUN, M_IDLE, M_SLEEP} mode_t;

  mode_t      mode_q;
  logic       idle_q;
  logic [1:0] sel_q, src_q, want;

  function automatic logic [1:0] norm(input logic [1:0] s);
    return (s == 2'b00) ? SRC_PRI : s;
  endfunction

  function automatic logic rdy_of(input logic [1:0] s);
    case (s)
      SRC_SEC: return sec_rdy;
      SRC_RC:  return rc_rdy;
      default: return pri_rdy;
    endcase
  endfunction

  assign want = wr_en ? norm(wr_src_sel) : norm(sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      idle_q <= 1'b0;
      sel_q  <= SRC_PRI;
      src_q  <= SRC_PRI;
    end else begin
      if (wr_en) begin
        idle_q <= wr_idle_en;
        sel_q  <= wr_src_sel;
      end
      if (rdy_of(want)) src_q <= want;
      case (mode_q)
        M_RUN:   if (sleep_cmd) mode_q <= idle_q ? M_IDLE : M_SLEEP;
        default: if (wake_cmd) mode_q <= M_RUN;
      endcase
    end
  end

  assign cpu_clk_en     = (mode_q == M_RUN);
  assign per_clk_en     = (mode_q != M_SLEEP);
  assign src_mux        = (mode_q == M_SLEEP) ? 2'b00 : src_q;
  assign mode_code      = (mode_q == M_SLEEP) ? 3'd0 : {mode_q == M_IDLE, src_q};
  assign switch_pending = (norm(sel_q) != src_q);

  a_r4_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && sleep_cmd && idle_q) |=> (cpu_clk_en == 1'b0 && per_clk_en == 1'b1));
  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && sleep_cmd && !idle_q) |=> (mode_code == 3'd0));
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && !wake_cmd) |=> (per_clk_en && !cpu_clk_en));
  a_r6_ready_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rdy_of(norm(wr_src_sel))) |=> !switch_pending);
  a_r7_hold_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && switch_pending && !rdy_of(norm(sel_q))) |=> $stable(src_q));
  a_r7_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && switch_pending && rdy_of(norm(sel_q))) |=> !switch_pending);
  a_r8_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !sleep_cmd) |=> cpu_clk_en);
  a_r2_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0) |-> (!cpu_clk_en && !per_clk_en && src_mux == 2'b00));
endmodule

// File: tb/pwr_clk_ctrl_tb.sv
module pwr_clk_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_idle_en = 0, sleep_cmd = 0, wake_cmd = 0;
  logic [1:0] wr_src_sel = 0;
  logic pri_rdy = 1, sec_rdy = 1, rc_rdy = 1;
  logic [1:0] src_mux;
  logic cpu_clk_en, per_clk_en, switch_pending;
  logic [2:0] mode_code;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  pwr_clk_ctrl dut_i (.clk, .rst_n, .wr_en, .wr_idle_en, .wr_src_sel, .sleep_cmd,
    .wake_cmd, .pri_rdy, .sec_rdy, .rc_rdy, .src_mux, .cpu_clk_en, .per_clk_en,
    .mode_code, .switch_pending);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    wr_en = 0; sleep_cmd = 0; wake_cmd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pri_rdy = 1; sec_rdy = 1; rc_rdy = 1;
    step(); rst_n = 1; step();
  endtask

  task automatic wr(input logic ie, input logic [1:0] s);
    wr_en = 1; wr_idle_en = ie; wr_src_sel = s;
  endtask

  task automatic set_rdy(input int src, input logic v);
    if (src == 1) sec_rdy = v; else if (src == 3) rc_rdy = v; else pri_rdy = v;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 code", mode_code, 2); chk("R1 mux", src_mux, 2);
    chk("R1 cpu", cpu_clk_en, 1); chk("R1 per", per_clk_en, 1);
    chk("R1 pend", switch_pending, 0);
    sleep_cmd = 1; step();
    chk("R1 idle-enable cleared -> sleep", mode_code, 0);

    for (int ie = 0; ie < 2; ie++)
      for (int s = 0; s < 4; s++) begin
        int src;
        src = (s == 0) ? 2 : s;
        do_reset();
        wr(ie[0], s[1:0]); step();
        chk("R3 R6 mux", src_mux, src);
        chk("R2 run code", mode_code, src);
        chk("R6 pend", switch_pending, 0);
        sleep_cmd = 1; step();
        chk("R4 R2 code", mode_code, ie ? (4 + src) : 0);
        chk("R2 cpu", cpu_clk_en, 0);
        chk("R2 per", per_clk_en, ie);
        chk("R9 mux", src_mux, ie ? src : 0);
        sleep_cmd = 1; step();
        chk("R8 sleep ignored", mode_code, ie ? (4 + src) : 0);
        wake_cmd = 1; step();
        chk("R8 wake", mode_code, src);
        chk("R8 wake cpu", cpu_clk_en, 1);
        wake_cmd = 1; step();
        chk("R8 wake in run ignored", mode_code, src);
      end

    do_reset();
    wr(1, 2'b10); sleep_cmd = 1; step();
    chk("R5 same-cycle write uses old value", mode_code, 0);
    wake_cmd = 1; step();
    sleep_cmd = 1; step();
    chk("R5 idle entry", mode_code, 6);
    wr(0, 2'b10); step(); step();
    chk("R5 later write no effect", mode_code, 6);

    for (int f = 1; f < 4; f++)
      for (int t = 1; t < 4; t++) begin
        if (f == t) continue;
        do_reset();
        wr(0, f[1:0]); step();
        set_rdy(t, 0);
        wr(0, t[1:0]); step();
        chk("R7 hold mux", src_mux, f);
        chk("R7 pend", switch_pending, 1);
        step();
        chk("R7 still hold", src_mux, f);
        set_rdy(t, 1); step();
        chk("R7 switched", src_mux, t);
        chk("R7 pend clear", switch_pending, 0);
      end

    do_reset();
    wr(1, 2'b01); step();
    sleep_cmd = 1; step();
    chk("R9 sec idle", mode_code, 5);
    wr(1, 2'b11); step();
    chk("R9 switch in idle", mode_code, 7);
    chk("R9 per on", per_clk_en, 1);
    wr(0, 2'b01); step();
    wake_cmd = 1; step();
    sleep_cmd = 1; step();
    chk("R9 sleep mux", src_mux, 0);
    wr(0, 2'b11); step();
    wake_cmd = 1; step();
    chk("R9 switch retained through sleep", src_mux, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule